// File: doc/BRIEF.md
# SCL Phase Generator for a Bus Master

This block is the timing engine underneath a two-wire serial bus master. A byte-level controller hands it one request at a time: begin a transfer, clock one data bit, issue a repeated begin, or end the transfer. The generator then steps through its phases and drives the clock and data lines through active-low pull-down enables. A released line is not driven and floats high through the bus pull-up. Each phase is timed by its own programmable count of module-clock ticks, so each protocol edge can be placed independently. The generator also reports which phase it is in.

After a begin or a bit, the generator parks with the clock held low and the data line at its last level, and it waits for the next request. A bit request runs a low phase, a release phase and a high phase, then pulls the clock low again. In the low phase the data line is held at its old level for the hold count before it takes the new bit. In the release phase the generator waits for the clock to actually read high, so that a slave can stretch the clock, but it stops waiting when the wait count runs out. A sample strobe marks the point at which the controller should capture incoming data. A one-cycle done pulse marks the end of each request.

Top module: `scl_phase_gen`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge (synchronous reset), the next cycle shows phase 0, both enables at 1 (released), `ready`=1 and `phase_done`=0. This holds even in the middle of a transfer.
- R2: `phase_code` reports the phase: 0 idle, 1 start, 2 falling edge, 3 low, 4 rising edge/wait, 5 high, 6 stop. No other value appears.
- R3: `cmd_op` encoding is 0 begin, 1 bit, 2 repeated begin, 3 end.
  - A begin request accepted in idle pulls the data line low at once, with the clock released, for `cfg_start_hold` ticks.
  - The clock is then pulled low for one tick (phase 2).
  - The generator then parks in phase 3, with `phase_done` set in the first parked cycle.
- R4: A bit request accepted while parked holds the clock low for `cfg_low` ticks.
  - During that time the data line keeps its previous level for `cfg_sda_hold` ticks and then takes `cmd_bit` (1 = released).
- R5: In phase 4 the clock is released.
  - The generator leaves phase 4 at the first tick at which `scl_in` reads 1.
  - If `scl_in` never reads 1, it leaves after `cfg_wait` ticks.
- R6: For a bit request, phase 5 lasts `cfg_high` ticks, phase 2 then lasts one tick, and the generator parks again with `phase_done`.
- R7: For a bit request, `sample_stb` pulses once, in the tick at which `cfg_sample` ticks have elapsed in the phase that `cfg_sample_low` selects.
  - `cfg_sample_low`=0 selects phase 5 (clock high).
  - `cfg_sample_low`=1 selects the active phase 3 (clock low).
- R8: A repeated-begin request runs a low phase that releases the data line, then phase 4.
  - Phase 5 then lasts `cfg_rstart_setup` ticks, with both lines released.
  - Phase 1 follows, with the data line pulled low for `cfg_start_hold` ticks.
  - The generator then falls and parks.
  - While the clock stays released, the data line changes only on entry to phase 1 or phase 6.
- R9: An end request runs a low phase that pulls the data line low, then phase 4.
  - Phase 5 then lasts `cfg_stop_setup` ticks with the data line low.
  - Phase 6 follows, with the data line released, for `cfg_stop_hold` ticks.
  - The generator then returns to idle with `phase_done`.
- R10: A begin request while parked, and any other request while idle, is ignored. Phase, line enables and `phase_done` stay unchanged.
- R11: Phase counters advance only in cycles where `tick` is 1. Cycles with `tick`=0 lengthen the current phase by their number.
- R12: `phase_done` is a single-cycle pulse and is only ever high while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timing tick enable for all phase counters |
| cmd_valid | input | 1 | Request strobe, taken when legal in the current state |
| cmd_op | input | 2 | Request: 0 begin, 1 bit, 2 repeated begin, 3 end |
| cmd_bit | input | 1 | Data level for a bit request (1 = release) |
| cfg_low | input | 9 | Clock low phase length in ticks |
| cfg_high | input | 9 | Clock high phase length in ticks |
| cfg_wait | input | 7 | Longest wait for the clock to read high |
| cfg_start_hold | input | 9 | Data-fall to clock-fall time for a begin |
| cfg_rstart_setup | input | 9 | Clock-high to data-fall time for a repeated begin |
| cfg_stop_setup | input | 9 | Clock-high to data-rise time for an end |
| cfg_stop_hold | input | 9 | Idle-line hold time after an end |
| cfg_sda_hold | input | 9 | Data hold after the start of the low phase |
| cfg_sample | input | 9 | Sample point within the sampling phase |
| cfg_sample_low | input | 1 | 0: sample in clock high, 1: sample in clock low |
| scl_in | input | 1 | Synchronized clock line level |
| scl_oe_n | output | 1 | Clock pull-down enable, active low |
| sda_oe_n | output | 1 | Data pull-down enable, active low |
| sample_stb | output | 1 | One-cycle strobe to capture incoming data |
| phase_done | output | 1 | One-cycle pulse at the end of each request |
| phase_code | output | 3 | Current phase code |
| ready | output | 1 | Idle or parked, able to take a request |

## Verification
A request is taken at the rising edge where `cmd_valid` is high. The first cycle after that edge is counted as cycle 1 of the new phase, and a phase of N ticks occupies exactly N cycles when `tick` stays high. The bench samples all outputs at the falling clock edge, one cycle at a time. It tallies how many cycles each phase code lasted, how many low-phase cycles kept the old data level, and how many cycles preceded the sample strobe. It stops at the cycle showing `phase_done` and compares the tallies with the programmed counts. The bench models stretching by holding `scl_in` low for a set number of released cycles. The wait phase is then due to last that number plus one cycles, or exactly `cfg_wait` cycles when the stretch outlasts it.

// File: rtl/sclgen_pkg.sv
// Shared phase and request encodings for the SCL phase generator.
package sclgen_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_FALL  = 3'd2,
        PH_LOW   = 3'd3,
        PH_RISE  = 3'd4,
        PH_HIGH  = 3'd5,
        PH_STOP  = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_BIT    = 2'd1,
        OP_RSTART = 2'd2,
        OP_STOP   = 2'd3
    } op_e;
endpackage

// File: rtl/sclgen_limit_sel.sv
// Picks the tick limit for the phase in progress.
// Assumes CNT_W > WAIT_W; the wait limit is zero-extended.
module sclgen_limit_sel
    import sclgen_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int WAIT_W = 7
) (
    input  phase_e             phase,
    input  op_e                op,
    input  logic [CNT_W-1:0]   cfg_low,
    input  logic [CNT_W-1:0]   cfg_high,
    input  logic [WAIT_W-1:0]  cfg_wait,
    input  logic [CNT_W-1:0]   cfg_start_hold,
    input  logic [CNT_W-1:0]   cfg_rstart_setup,
    input  logic [CNT_W-1:0]   cfg_stop_setup,
    input  logic [CNT_W-1:0]   cfg_stop_hold,
    output logic [CNT_W-1:0]   limit
);
    localparam int PAD = CNT_W - WAIT_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Limit lookup by phase, and by request during the high phase.
    always_comb begin
        case (phase)
            PH_START: limit = cfg_start_hold;
            PH_LOW:   limit = cfg_low;
            PH_RISE:  limit = {{PAD{1'b0}}, cfg_wait};
            PH_HIGH: begin
                case (op)
                    OP_RSTART: limit = cfg_rstart_setup;
                    OP_STOP:   limit = cfg_stop_setup;
                    default:   limit = cfg_high;
                endcase
            end
            PH_STOP:  limit = cfg_stop_hold;
            default:  limit = ONE;
        endcase
    end
endmodule

// File: rtl/sclgen_counter.sv
// Tick counter for one phase. It clears on request, advances on tick and
// saturates at all ones. It flags the tick that completes the limit; a
// limit of 0 acts as 1.
module sclgen_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    logic [CNT_W:0] cnt_inc;

    // Count after this tick, widened so that no carry is lost.
    always_comb cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

    // Compare the count after this tick against the limit.
    always_comb last = (cnt_inc >= {1'b0, limit});

    // Phase tick counter with synchronous clear and saturation.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (tick && (cnt != {CNT_W{1'b1}})) begin
            cnt <= cnt_inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/sclgen_fsm.sv
// Phase sequencer. It takes legal requests, walks through the phases,
// holds the data line level and raises the done pulse and sample strobe.
// Assumes scl_in is already synchronized to clk.
module sclgen_fsm
    import sclgen_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bit,
    input  logic [CNT_W-1:0] cnt,
    input  logic             last,
    input  logic [CNT_W-1:0] cfg_sda_hold,
    input  logic [CNT_W-1:0] cfg_sample,
    input  logic             cfg_sample_low,
    input  logic             scl_in,
    output phase_e           phase,
    output op_e              op,
    output logic             sda_lvl,
    output logic             done,
    output logic             sample_stb,
    output logic             ready,
    output logic             clr
);
    logic   parked;
    logic   bit_r;
    logic   accept;
    logic   leave;
    logic   busy;
    logic   tgt;
    logic   hold_hit;
    phase_e nxt;
    op_e    req;

    // Request decode and legality against the current phase.
    always_comb begin
        req    = op_e'(cmd_op);
        ready  = (phase == PH_IDLE) || ((phase == PH_LOW) && parked);
        accept = cmd_valid &&
                 (((phase == PH_IDLE) && (req == OP_START)) ||
                  ((phase == PH_LOW) && parked && (req != OP_START)));
    end

    // Exit condition of a timed phase; the wait phase also exits on a high clock.
    always_comb begin
        busy  = !ready;
        leave = busy && tick && ((phase == PH_RISE) ? (scl_in || last) : last);
        clr   = accept || leave;
    end

    // Data level that the current request drives during its low phase.
    always_comb begin
        case (op)
            OP_BIT:    tgt = bit_r;
            OP_RSTART: tgt = 1'b1;
            default:   tgt = 1'b0;
        endcase
        hold_hit = (({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, cfg_sda_hold});
    end

    // Phase that follows the current one.
    always_comb begin
        case (phase)
            PH_START: nxt = PH_FALL;
            PH_FALL:  nxt = PH_LOW;
            PH_LOW:   nxt = PH_RISE;
            PH_RISE:  nxt = PH_HIGH;
            PH_HIGH: begin
                case (op)
                    OP_RSTART: nxt = PH_START;
                    OP_STOP:   nxt = PH_STOP;
                    default:   nxt = PH_FALL;
                endcase
            end
            default:  nxt = PH_IDLE;
        endcase
    end

    // Sample strobe in the phase that the sampling mode selects.
    always_comb begin
        sample_stb = tick && (op == OP_BIT) && (cnt == cfg_sample) &&
                     (cfg_sample_low ? ((phase == PH_LOW) && !parked)
                                     : (phase == PH_HIGH));
    end

    // Phase, request and data line state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            op      <= OP_START;
            parked  <= 1'b0;
            bit_r   <= 1'b0;
            sda_lvl <= 1'b1;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op    <= req;
                bit_r <= cmd_bit;
                if (phase == PH_IDLE) begin
                    phase   <= PH_START;
                    sda_lvl <= 1'b0;
                end else begin
                    parked <= 1'b0;
                end
            end else if (leave) begin
                phase <= nxt;
                case (phase)
                    PH_LOW:  sda_lvl <= tgt;
                    PH_HIGH: begin
                        if (op == OP_RSTART) sda_lvl <= 1'b0;
                        else if (op == OP_STOP) sda_lvl <= 1'b1;
                    end
                    PH_FALL: begin
                        parked <= 1'b1;
                        done   <= 1'b1;
                    end
                    PH_STOP: done <= 1'b1;
                    default: ;
                endcase
            end else if ((phase == PH_LOW) && !parked && tick && hold_hit) begin
                sda_lvl <= tgt;
            end
        end
    end
endmodule

// File: rtl/scl_phase_gen.sv
// Top of the SCL phase generator. It ties the limit selector, the phase
// counter and the sequencer together and decodes the line enables.
// Assumes external pull-ups and a synchronized scl_in.
module scl_phase_gen
    import sclgen_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int WAIT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_bit,
    input  logic [CNT_W-1:0]  cfg_low,
    input  logic [CNT_W-1:0]  cfg_high,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [CNT_W-1:0]  cfg_start_hold,
    input  logic [CNT_W-1:0]  cfg_rstart_setup,
    input  logic [CNT_W-1:0]  cfg_stop_setup,
    input  logic [CNT_W-1:0]  cfg_stop_hold,
    input  logic [CNT_W-1:0]  cfg_sda_hold,
    input  logic [CNT_W-1:0]  cfg_sample,
    input  logic              cfg_sample_low,
    input  logic              scl_in,
    output logic              scl_oe_n,
    output logic              sda_oe_n,
    output logic              sample_stb,
    output logic              phase_done,
    output logic [2:0]        phase_code,
    output logic              ready
);
    phase_e           phase;
    op_e              op;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             clr;
    logic             sda_lvl;

    sclgen_limit_sel #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_limit (
        .phase            (phase),
        .op               (op),
        .cfg_low          (cfg_low),
        .cfg_high         (cfg_high),
        .cfg_wait         (cfg_wait),
        .cfg_start_hold   (cfg_start_hold),
        .cfg_rstart_setup (cfg_rstart_setup),
        .cfg_stop_setup   (cfg_stop_setup),
        .cfg_stop_hold    (cfg_stop_hold),
        .limit            (limit)
    );

    sclgen_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick),
        .limit (limit),
        .cnt   (cnt),
        .last  (last)
    );

    sclgen_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_bit        (cmd_bit),
        .cnt            (cnt),
        .last           (last),
        .cfg_sda_hold   (cfg_sda_hold),
        .cfg_sample     (cfg_sample),
        .cfg_sample_low (cfg_sample_low),
        .scl_in         (scl_in),
        .phase          (phase),
        .op             (op),
        .sda_lvl        (sda_lvl),
        .done           (phase_done),
        .sample_stb     (sample_stb),
        .ready          (ready),
        .clr            (clr)
    );

    // Line enables and phase report decoded from registered state.
    always_comb begin
        scl_oe_n   = !((phase == PH_FALL) || (phase == PH_LOW));
        sda_oe_n   = sda_lvl;
        phase_code = phase;
    end
endmodule

// File: rtl/sclgen_checker.sv
// Protocol checks on the generator ports, attached by bind.
module sclgen_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       scl_oe_n,
    input logic       sda_oe_n,
    input logic       sample_stb,
    input logic       phase_done,
    input logic [2:0] phase_code,
    input logic       ready
);
    assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_code <= 3'd6);

    assert_sda_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe_n && $past(scl_oe_n) && !$stable(sda_oe_n))
        |-> (phase_code == 3'd1 || phase_code == 3'd6));

    assert_wait_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 3'd4) |-> scl_oe_n);

    assert_fall_one_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 3'd2 && tick) |=> (phase_code == 3'd3));

    assert_strobe_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (phase_code == 3'd3 || phase_code == 3'd5));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |=> !phase_done);

    assert_done_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        phase_done |-> ready);
endmodule

bind scl_phase_gen sclgen_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .scl_oe_n   (scl_oe_n),
    .sda_oe_n   (sda_oe_n),
    .sample_stb (sample_stb),
    .phase_done (phase_done),
    .phase_code (phase_code),
    .ready      (ready)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_bit = 1'b0;
    logic [8:0] cfg_low = 9'd6, cfg_high = 9'd4, cfg_start_hold = 9'd5;
    logic [8:0] cfg_rstart_setup = 9'd3, cfg_stop_setup = 9'd4, cfg_stop_hold = 9'd6;
    logic [8:0] cfg_sda_hold = 9'd2, cfg_sample = 9'd1;
    logic [6:0] cfg_wait = 7'd20;
    logic       cfg_sample_low = 1'b0;
    logic       scl_in = 1'b1;
    logic       scl_oe_n, sda_oe_n, sample_stb, phase_done, ready;
    logic [2:0] phase_code;

    int n_chk = 0, n_fail = 0, stretch_left = 0;
    int n_st[8];
    int n_old, n_strobe, pos_low, pos_high, n_hi_sda_low, got_done;
    bit finished = 1'b0, gap_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_phase_gen u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cfg_low(cfg_low), .cfg_high(cfg_high),
        .cfg_wait(cfg_wait), .cfg_start_hold(cfg_start_hold),
        .cfg_rstart_setup(cfg_rstart_setup), .cfg_stop_setup(cfg_stop_setup),
        .cfg_stop_hold(cfg_stop_hold), .cfg_sda_hold(cfg_sda_hold),
        .cfg_sample(cfg_sample), .cfg_sample_low(cfg_sample_low), .scl_in(scl_in),
        .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .sample_stb(sample_stb),
        .phase_done(phase_done), .phase_code(phase_code), .ready(ready)
    );

    // Bus model: wired-AND clock with an optional stretching slave.
    always @(negedge clk) begin
        if (!scl_oe_n) scl_in <= 1'b0;
        else if (stretch_left > 0) begin
            scl_in <= 1'b0;
            stretch_left <= stretch_left - 1;
        end else scl_in <= 1'b1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input int op, input bit b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Tally phases cycle by cycle until the done pulse is seen.
    task automatic measure(input bit old_sda);
        foreach (n_st[i]) n_st[i] = 0;
        n_old = 0; n_strobe = 0; pos_low = -1; pos_high = -1; n_hi_sda_low = 0; got_done = 0;
        for (int c = 1; c <= 400; c++) begin
            tick = gap_mode ? !(c >= 3 && c <= 12) : 1'b1;
            if (phase_done) begin got_done = 1; break; end
            if (sample_stb) begin n_strobe++; pos_low = n_st[3]; pos_high = n_st[5]; end
            if (phase_code == 3'd3 && sda_oe_n == old_sda) n_old++;
            if (phase_code == 3'd5 && !sda_oe_n) n_hi_sda_low++;
            n_st[phase_code]++;
            @(negedge clk);
        end
        tick = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R1", "phase after reset", phase_code, 0);
        check("R1", "scl released", scl_oe_n, 1);
        check("R1", "sda released", sda_oe_n, 1);
        check("R1", "ready", ready, 1);
        check("R12", "no done", phase_done, 0);
    endtask

    task automatic t_ignored(input int op, input int exp_phase);
        int bad = 0;
        logic s0, c0;
        s0 = sda_oe_n; c0 = scl_oe_n;
        issue(op, 1'b1);
        for (int c = 0; c < 20; c++) begin
            if (phase_code != exp_phase[2:0] || phase_done || sda_oe_n != s0 || scl_oe_n != c0) bad++;
            @(negedge clk);
        end
        check("R10", "cycles changed by illegal request", bad, 0);
    endtask

    task automatic t_start();
        issue(0, 1'b0);
        measure(1'b0);
        check("R3", "start phase cycles", n_st[1], 5);
        check("R3", "fall phase cycles", n_st[2], 1);
        check("R3", "done seen", got_done, 1);
        check("R3", "parked phase", phase_code, 3);
        check("R3", "sda low when parked", sda_oe_n, 0);
        @(negedge clk);
        check("R12", "done single cycle", phase_done, 0);
    endtask

    task automatic t_bit(input bit b, input bit old, input int stretch, input int exp_rise,
                         input bit low_mode, input int smp);
        cfg_sample_low = low_mode; cfg_sample = smp[8:0];
        stretch_left = stretch;
        issue(1, b);
        measure(old);
        stretch_left = 0;
        check("R4", "low phase cycles", n_st[3], 6);
        check("R4", "old sda cycles in low", n_old, 2);
        check("R5", "wait phase cycles", n_st[4], exp_rise);
        check("R6", "high phase cycles", n_st[5], 4);
        check("R6", "fall cycles", n_st[2], 1);
        check("R7", "strobe count", n_strobe, 1);
        if (low_mode) check("R7", "strobe low position", pos_low, smp);
        else check("R7", "strobe high position", pos_high, smp);
        check("R4", "bit on sda at park", sda_oe_n, b);
        check("R6", "done and parked", got_done * 10 + phase_code, 13);
    endtask

    task automatic t_rstart();
        issue(2, 1'b0);
        measure(1'b1);
        check("R8", "low cycles", n_st[3], 6);
        check("R8", "setup cycles", n_st[5], 3);
        check("R8", "sda low during setup", n_hi_sda_low, 0);
        check("R8", "start hold cycles", n_st[1], 5);
        check("R8", "done and parked", got_done * 10 + phase_code, 13);
    endtask

    task automatic t_stop();
        issue(3, 1'b0);
        measure(1'b1);
        check("R9", "setup cycles", n_st[5], 4);
        check("R9", "sda low in setup", n_hi_sda_low, 4);
        check("R9", "stop hold cycles", n_st[6], 6);
        check("R9", "done and idle", got_done * 10 + phase_code, 10);
        check("R9", "lines released", {30'd0, scl_oe_n, sda_oe_n}, 3);
    endtask

    task automatic t_tick_gap();
        gap_mode = 1'b1;
        issue(0, 1'b0);
        measure(1'b0);
        gap_mode = 1'b0;
        check("R11", "start cycles with 10 idle ticks", n_st[1], 15);
        check("R11", "parked after gap", phase_code, 3);
    endtask

    task automatic t_reset_mid();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1", "phase after mid reset", phase_code, 0);
        check("R1", "lines after mid reset", {30'd0, scl_oe_n, sda_oe_n}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ignored(1, 0);
        t_start();
        t_ignored(0, 3);
        t_bit(1'b1, 1'b0, 0, 1, 1'b0, 1);
        t_bit(1'b0, 1'b1, 5, 6, 1'b1, 3);
        cfg_wait = 7'd4;
        t_bit(1'b1, 1'b0, 30, 4, 1'b0, 2);
        cfg_wait = 7'd20;
        t_rstart();
        t_stop();
        t_tick_gap();
        t_reset_mid();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule